// File: doc/BRIEF.md
# DRAM Controller Performance Counter Unit

This block watches a DRAM controller and counts what it does. It has a bank of programmable event counters and two fixed counters that run freely, one for DRAM reads and one for DRAM writes. Software reaches it through a 64-bit register port with separate write and read strobes and a byte address. Each cycle the controller drives a vector of event lines and one pulse each for a completed DRAM read and a completed DRAM write.

Each programmable counter has a configuration word. The word holds an event mask and an enable bit. The counter advances by one in every cycle in which at least one masked event line is high. The bank counts only between a start operation and an end operation. A start issued from the stopped state zeroes the bank. A programmable counter that reaches its maximum stays there. The free-running counters have their own enable bits and clear bits. They count whether the bank is running or not, and on overflow they wrap and record it in a sticky flag.

Top module: `memPerfMon`

## Requirements
- R1: After reset every mapped register reads zero, the bank is stopped and the end-status flag is clear.
- R2: Bit 0 of offset 0x8020 is a read/write manual-mode flag. A start operation takes effect only while this flag is 1.
- R3: Writing 1 to bit 0 of offset 0x8028 starts the bank. Reading 0x8028 returns the running state in bit 1. A start issued while stopped zeroes every programmable value and its flag. A start issued while running changes no value.
- R4: Writing 1 to bit 0 of offset 0x8030 stops the bank and sets bit 0 of offset 0x8038. The next accepted start clears that bit. While stopped, programmable values hold.
- R5: The configuration word of counter n sits at 0x8040 + 8·n. Bit 63 enables the counter and bits [EVT_W-1:0] are its event mask. The word reads back as written.
- R6: Mask bit k selects event line k, which corresponds to event id k+1. A multi-line field, such as the 4-bit groups for ids 27, 31 and 35, still adds at most one per cycle. A counter advances only while it is enabled and the bank runs.
- R7: The value of counter n reads at 0x8080 + 8·n, with the count in bits [CNT_W-1:0] and a saturation flag in bit CNT_W. When the count reaches all ones the flag sets and the value holds until an accepted start.
- R8: At offset 0x80C0, bit 0 enables the free-running write counter and bit 1 enables the read counter. Both bits are read/write. Neither counter depends on the bank state.
- R9: Writing offset 0x80C8 clears the write counter through bit 0 and the read counter through bit 1. A clear wins over a pulse in the same cycle. The offset reads zero.
- R10: The free-running write value reads at 0x80D0 and the read value at 0x80D8. Each wraps to zero past all ones and sets a sticky overflow flag in bit CNT_W, which only a clear removes.
- R11: Reads of unmapped or misaligned offsets return zero. Writes to them change nothing.
- R12: Read data and the read-valid flag appear one cycle after the read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe |
| regAddr | input | 16 | Byte offset of the access |
| wrData | input | 64 | Write data |
| rdData | output | 64 | Registered read data |
| rdValid | output | 1 | Read data valid, one cycle after rdEn |
| evtIn | input | EVT_W | Per-cycle event lines from the controller |
| ddrRdPulse | input | 1 | One DRAM read completed this cycle |
| ddrWrPulse | input | 1 | One DRAM write completed this cycle |

## Verification
Counting is driven three ways. Single-line pulses show that the mask selects the right line. Pulses on several lines at once, including inside a 4-bit group, show that a cycle counts once and not once per line. Long random event vectors against a mixed set of masks show that counters do not interfere with each other. A long run on one line drives a narrowed counter into saturation, and the same kind of run drives a free-running counter past its wrap, which separates holding from wrapping. Further sequences check that values freeze across a stop, that only a start from the stopped state clears them, and that a clear wins over a same-cycle pulse.

// File: rtl/memPerfPkg.sv
package memPerfPkg;
  localparam int REG_AW = 16;

  localparam logic [REG_AW-1:0] MODE_OFS   = 16'h8020;
  localparam logic [REG_AW-1:0] START_OFS  = 16'h8028;
  localparam logic [REG_AW-1:0] END_OFS    = 16'h8030;
  localparam logic [REG_AW-1:0] ENDST_OFS  = 16'h8038;
  localparam logic [REG_AW-1:0] CFG_BASE   = 16'h8040;
  localparam logic [REG_AW-1:0] VAL_BASE   = 16'h8080;
  localparam logic [REG_AW-1:0] FREN_OFS   = 16'h80C0;
  localparam logic [REG_AW-1:0] FRCTL_OFS  = 16'h80C8;
  localparam logic [REG_AW-1:0] FRWR_OFS   = 16'h80D0;
  localparam logic [REG_AW-1:0] FRRD_OFS   = 16'h80D8;

  // Strobes from control to datapath
  typedef struct packed {
    logic clearBank;   // zero every programmable counter
    logic bankActive;  // programmable bank counting
    logic frWrEn;
    logic frRdEn;
    logic frWrClr;
    logic frRdClr;
  } ctlStrobes_t;
endpackage

// File: rtl/memPerfCtrl.sv
module memPerfCtrl
  import memPerfPkg::*;
#(
  parameter int NUM_PROG = 8,
  parameter int EVT_W    = 56,
  parameter int CNT_W    = 48
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  logic                               wrEn,
  input  logic                               rdEn,
  input  logic [REG_AW-1:0]                  regAddr,
  input  logic [63:0]                        wrData,
  input  logic [NUM_PROG-1:0][CNT_W:0]       progVal,
  input  logic [CNT_W:0]                     frWrVal,
  input  logic [CNT_W:0]                     frRdVal,
  output logic [NUM_PROG-1:0][EVT_W-1:0]     cfgMap,
  output logic [NUM_PROG-1:0]                cfgEn,
  output ctlStrobes_t                        strobes,
  output logic [63:0]                        rdData,
  output logic                               rdValid
);
  localparam int IDX_W = (NUM_PROG > 1) ? $clog2(NUM_PROG) : 1;
  localparam logic [REG_AW-1:0] CFG_END = CFG_BASE + REG_AW'(8 * NUM_PROG);
  localparam logic [REG_AW-1:0] VAL_END = VAL_BASE + REG_AW'(8 * NUM_PROG);

  logic modeManual, bankActive, endDone, frEnWr, frEnRd;
  logic aligned, isCfg, isVal;
  logic [REG_AW-1:0] cfgOfs, valOfs;
  logic [IDX_W-1:0] cfgIdx, valIdx;
  logic startHit, endHit, clearBank;
  logic [63:0] rdNext;

  assign aligned = (regAddr[2:0] == 3'b000);
  assign isCfg   = aligned && (regAddr >= CFG_BASE) && (regAddr < CFG_END);
  assign isVal   = aligned && (regAddr >= VAL_BASE) && (regAddr < VAL_END);
  assign cfgOfs  = regAddr - CFG_BASE;
  assign valOfs  = regAddr - VAL_BASE;
  assign cfgIdx  = cfgOfs[IDX_W+2:3];
  assign valIdx  = valOfs[IDX_W+2:3];

  assign startHit  = wrEn && (regAddr == START_OFS) && wrData[0] && modeManual;
  assign endHit    = wrEn && (regAddr == END_OFS) && wrData[0];
  assign clearBank = startHit && !bankActive;

  // Global mode, run state and end status
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeManual <= 1'b0;
      bankActive <= 1'b0;
      endDone    <= 1'b0;
      frEnWr     <= 1'b0;
      frEnRd     <= 1'b0;
    end else begin
      if (wrEn && regAddr == MODE_OFS) modeManual <= wrData[0];
      if (wrEn && regAddr == FREN_OFS) begin
        frEnWr <= wrData[0];
        frEnRd <= wrData[1];
      end
      if (startHit) begin
        bankActive <= 1'b1;
        endDone    <= 1'b0;
      end else if (endHit) begin
        bankActive <= 1'b0;
        endDone    <= 1'b1;
      end
    end
  end

  // Configuration words
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgMap <= '0;
      cfgEn  <= '0;
    end else if (wrEn && isCfg) begin
      for (int i = 0; i < NUM_PROG; i++) begin
        if (cfgIdx == IDX_W'(i)) begin
          cfgMap[i] <= wrData[EVT_W-1:0];
          cfgEn[i]  <= wrData[63];
        end
      end
    end
  end

  always_comb begin
    strobes.clearBank  = clearBank;
    strobes.bankActive = bankActive;
    strobes.frWrEn     = frEnWr;
    strobes.frRdEn     = frEnRd;
    strobes.frWrClr    = wrEn && (regAddr == FRCTL_OFS) && wrData[0];
    strobes.frRdClr    = wrEn && (regAddr == FRCTL_OFS) && wrData[1];
  end

  // Read decode
  always_comb begin
    rdNext = '0;
    if (isCfg) begin
      rdNext[EVT_W-1:0] = cfgMap[cfgIdx];
      rdNext[63]        = cfgEn[cfgIdx];
    end else if (isVal) begin
      rdNext = 64'(progVal[valIdx]);
    end else begin
      case (regAddr)
        MODE_OFS:  rdNext[0]   = modeManual;
        START_OFS: rdNext[1]   = bankActive;
        ENDST_OFS: rdNext[0]   = endDone;
        FREN_OFS:  rdNext[1:0] = {frEnRd, frEnWr};
        FRWR_OFS:  rdNext      = 64'(frWrVal);
        FRRD_OFS:  rdNext      = 64'(frRdVal);
        default:   rdNext      = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdData  <= '0;
      rdValid <= 1'b0;
    end else begin
      rdValid <= rdEn;
      if (rdEn) rdData <= rdNext;
    end
  end
endmodule

// File: rtl/memPerfFreeCnt.sv
module memPerfFreeCnt #(
  parameter int CNT_W = 48
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           cntEn,
  input  logic           cntClr,
  input  logic           pulse,
  output logic [CNT_W:0] cntVal
);
  logic [CNT_W-1:0] count;
  logic             wrapped;
  logic [CNT_W:0]   sum;

  assign sum = {1'b0, count} + 1'b1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count   <= '0;
      wrapped <= 1'b0;
    end else if (cntClr) begin
      count   <= '0;
      wrapped <= 1'b0;
    end else if (cntEn && pulse) begin
      count   <= sum[CNT_W-1:0];
      wrapped <= wrapped | sum[CNT_W];
    end
  end

  assign cntVal = {wrapped, count};
endmodule

// File: rtl/memPerfDatapath.sv
module memPerfDatapath
  import memPerfPkg::*;
#(
  parameter int NUM_PROG = 8,
  parameter int EVT_W    = 56,
  parameter int CNT_W    = 48
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  ctlStrobes_t                    strobes,
  input  logic [NUM_PROG-1:0][EVT_W-1:0] cfgMap,
  input  logic [NUM_PROG-1:0]            cfgEn,
  input  logic [EVT_W-1:0]               evtIn,
  input  logic                           ddrRdPulse,
  input  logic                           ddrWrPulse,
  output logic [NUM_PROG-1:0][CNT_W:0]   progVal,
  output logic [CNT_W:0]                 frWrVal,
  output logic [CNT_W:0]                 frRdVal
);
  localparam logic [CNT_W-1:0] NEAR_MAX = {{(CNT_W-1){1'b1}}, 1'b0};

  for (genvar i = 0; i < NUM_PROG; i++) begin : g_prog
    logic             hit;
    logic             sat;
    logic [CNT_W-1:0] cnt;

    assign hit = cfgEn[i] && (|(cfgMap[i] & evtIn));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        cnt <= '0;
        sat <= 1'b0;
      end else if (strobes.clearBank) begin
        cnt <= '0;
        sat <= 1'b0;
      end else if (strobes.bankActive && hit && !sat) begin
        cnt <= cnt + 1'b1;
        if (cnt == NEAR_MAX) sat <= 1'b1;
      end
    end

    assign progVal[i] = {sat, cnt};
  end

  memPerfFreeCnt #(.CNT_W(CNT_W)) i_frWr (
    .clk    (clk),
    .rstN   (rstN),
    .cntEn  (strobes.frWrEn),
    .cntClr (strobes.frWrClr),
    .pulse  (ddrWrPulse),
    .cntVal (frWrVal)
  );

  memPerfFreeCnt #(.CNT_W(CNT_W)) i_frRd (
    .clk    (clk),
    .rstN   (rstN),
    .cntEn  (strobes.frRdEn),
    .cntClr (strobes.frRdClr),
    .pulse  (ddrRdPulse),
    .cntVal (frRdVal)
  );
endmodule

// File: rtl/memPerfMon.sv
module memPerfMon
  import memPerfPkg::*;
#(
  parameter int NUM_PROG = 8,
  parameter int EVT_W    = 56,
  parameter int CNT_W    = 48
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [15:0]       regAddr,
  input  logic [63:0]       wrData,
  output logic [63:0]       rdData,
  output logic              rdValid,
  input  logic [EVT_W-1:0]  evtIn,
  input  logic              ddrRdPulse,
  input  logic              ddrWrPulse
);
  ctlStrobes_t                    strobes;
  logic [NUM_PROG-1:0][EVT_W-1:0] cfgMap;
  logic [NUM_PROG-1:0]            cfgEn;
  logic [NUM_PROG-1:0][CNT_W:0]   progVal;
  logic [CNT_W:0]                 frWrVal;
  logic [CNT_W:0]                 frRdVal;

  memPerfCtrl #(.NUM_PROG(NUM_PROG), .EVT_W(EVT_W), .CNT_W(CNT_W)) i_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .wrEn    (wrEn),
    .rdEn    (rdEn),
    .regAddr (regAddr),
    .wrData  (wrData),
    .progVal (progVal),
    .frWrVal (frWrVal),
    .frRdVal (frRdVal),
    .cfgMap  (cfgMap),
    .cfgEn   (cfgEn),
    .strobes (strobes),
    .rdData  (rdData),
    .rdValid (rdValid)
  );

  memPerfDatapath #(.NUM_PROG(NUM_PROG), .EVT_W(EVT_W), .CNT_W(CNT_W)) i_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .cfgMap     (cfgMap),
    .cfgEn      (cfgEn),
    .evtIn      (evtIn),
    .ddrRdPulse (ddrRdPulse),
    .ddrWrPulse (ddrWrPulse),
    .progVal    (progVal),
    .frWrVal    (frWrVal),
    .frRdVal    (frRdVal)
  );
endmodule

// File: rtl/memPerfMonChk.sv
module memPerfMonChk
  import memPerfPkg::*;
#(
  parameter int NUM_PROG = 8,
  parameter int CNT_W    = 48
) (
  input logic                         clk,
  input logic                         rstN,
  input logic                         rdEn,
  input logic                         rdValid,
  input ctlStrobes_t                  strobes,
  input logic [NUM_PROG-1:0][CNT_W:0] progVal,
  input logic [CNT_W:0]               frWrVal,
  input logic [CNT_W:0]               frRdVal
);
  p_rd_valid_r12: assert property (@(posedge clk) disable iff (!rstN)
    rdEn |=> rdValid);
  p_rd_idle_r12: assert property (@(posedge clk) disable iff (!rstN)
    !rdEn |=> !rdValid);
  p_fr_wr_clear_r9: assert property (@(posedge clk) disable iff (!rstN)
    strobes.frWrClr |=> (frWrVal == '0));
  p_fr_rd_clear_r9: assert property (@(posedge clk) disable iff (!rstN)
    strobes.frRdClr |=> (frRdVal == '0));

  for (genvar i = 0; i < NUM_PROG; i++) begin : g_chk
    p_bank_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
      (!strobes.bankActive && !strobes.clearBank) |=> $stable(progVal[i]));
    p_single_step_r6: assert property (@(posedge clk) disable iff (!rstN)
      !strobes.clearBank |=>
        ((progVal[i][CNT_W-1:0] - $past(progVal[i][CNT_W-1:0])) <= CNT_W'(1)));
    p_sat_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
      (progVal[i][CNT_W] && !strobes.clearBank) |=> $stable(progVal[i]));
    p_start_clear_r3: assert property (@(posedge clk) disable iff (!rstN)
      strobes.clearBank |=> (progVal[i] == '0));
  end
endmodule

bind memPerfMon memPerfMonChk #(.NUM_PROG(NUM_PROG), .CNT_W(CNT_W)) u_memPerfMonChk (
  .clk     (clk),
  .rstN    (rstN),
  .rdEn    (rdEn),
  .rdValid (rdValid),
  .strobes (strobes),
  .progVal (progVal),
  .frWrVal (frWrVal),
  .frRdVal (frRdVal)
);

// File: tb/test_memPerfMon.sv
`timescale 1ns/1ps
module test_memPerfMon;
  localparam int EVT_W = 56;
  localparam int CNT_W = 8;
  localparam int CMAX  = (1 << CNT_W) - 1;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             wrEn = 1'b0, rdEn = 1'b0;
  logic [15:0]      regAddr = '0;
  logic [63:0]      wrData = '0;
  logic [63:0]      rdData;
  logic             rdValid;
  logic [EVT_W-1:0] evtIn = '0;
  logic             ddrRdPulse = 1'b0, ddrWrPulse = 1'b0;

  int total = 0, bad = 0;
  bit done = 0;
  bit lastValid;

  // Bench model of programmable counters 0..3
  logic [EVT_W-1:0] mMap [4];
  bit               mEn  [4];
  int               mCnt [4];
  bit               mActive = 0;

  always #10 clk = ~clk;

  memPerfMon #(.NUM_PROG(8), .EVT_W(EVT_W), .CNT_W(CNT_W)) i_memPerfMon (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .regAddr(regAddr),
    .wrData(wrData), .rdData(rdData), .rdValid(rdValid), .evtIn(evtIn),
    .ddrRdPulse(ddrRdPulse), .ddrWrPulse(ddrWrPulse));

  function automatic logic [63:0] expProg(int c);
    return (c == CMAX) ? 64'(CMAX | (1 << CNT_W)) : 64'(c);
  endfunction

  task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic regWr(input logic [15:0] a, input logic [63:0] d);
    @(negedge clk);
    evtIn = '0; ddrRdPulse = 0; ddrWrPulse = 0;
    wrEn = 1; regAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 0;
  endtask

  task automatic regRd(input logic [15:0] a, output logic [63:0] d);
    @(negedge clk);
    evtIn = '0; ddrRdPulse = 0; ddrWrPulse = 0;
    rdEn = 1; regAddr = a;
    @(negedge clk);
    rdEn = 0;
    d = rdData;
    lastValid = rdValid;
  endtask

  task automatic stepEvt(input logic [EVT_W-1:0] e, input bit wp, input bit rp);
    @(negedge clk);
    evtIn = e; ddrWrPulse = wp; ddrRdPulse = rp;
    if (mActive)
      for (int i = 0; i < 4; i++)
        if (mEn[i] && ((mMap[i] & e) != '0) && mCnt[i] < CMAX) mCnt[i]++;
  endtask

  task automatic setCfg(input int n, input bit en, input logic [EVT_W-1:0] m);
    regWr(16'h8040 + 16'(8 * n), {en, 63'(m)});
    mEn[n] = en; mMap[n] = m;
  endtask

  task automatic chkBank(input string req);
    logic [63:0] v;
    for (int i = 0; i < 4; i++) begin
      regRd(16'h8080 + 16'(8 * i), v);
      chk(req, v, expProg(mCnt[i]));
    end
  endtask

  initial begin
    logic [63:0] v;
    int unused;
    unused = $urandom(32'h5EED1);
    for (int i = 0; i < 4; i++) begin mMap[i] = '0; mEn[i] = 0; mCnt[i] = 0; end
    repeat (3) @(negedge clk);
    rstN = 1;

    // R1 reset state
    regRd(16'h8028, v); chk("R1 run state", v, 0);
    regRd(16'h8038, v); chk("R1 end status", v, 0);
    regRd(16'h8080, v); chk("R1 counter0", v, 0);
    regRd(16'h80D0, v); chk("R1 free write", v, 0);
    // R12 read timing
    chk("R12 valid after strobe", 64'(lastValid), 1);
    @(negedge clk); chk("R12 valid drops", 64'(rdValid), 0);

    // R2 start ignored outside manual mode
    regWr(16'h8028, 1);
    regRd(16'h8028, v); chk("R2 start gated", v, 0);
    regWr(16'h8020, 1);
    regRd(16'h8020, v); chk("R2 mode readback", v, 1);

    // R5 configuration
    setCfg(0, 1, 56'h4);                    // id 3
    setCfg(1, 1, 56'hF << 26);              // id 27 group
    setCfg(2, 0, 56'h1);                    // disabled
    setCfg(3, 1, {$urandom, $urandom} & 56'h00FF_FF00_FF00_FF);
    regRd(16'h8048, v); chk("R5 cfg1 readback", v, 64'h8000_0000_3C00_0000);

    // R11 unmapped and misaligned
    regWr(16'h8044, 64'hFFFF);
    regRd(16'h8040, v); chk("R11 misaligned write ignored", v, 64'h8000_0000_0000_0004);
    regRd(16'h8044, v); chk("R11 misaligned read", v, 0);
    regWr(16'h8000, 64'h1234);
    regRd(16'h8000, v); chk("R11 unmapped read", v, 0);

    // R3 start
    regWr(16'h8028, 1); mActive = 1;
    regRd(16'h8028, v); chk("R3 running bit", v, 2);

    // R6 directed patterns
    repeat (5) stepEvt(56'h4, 0, 0);
    repeat (3) stepEvt(56'h1 << 28, 0, 0);
    repeat (2) stepEvt(56'hC | (56'h3 << 26), 0, 0);
    repeat (4) stepEvt(56'h1, 0, 0);
    chkBank("R6 directed");
    regRd(16'h80B8, v); chk("R6 unconfigured counter7", v, 0);

    // R6 random patterns
    for (int k = 0; k < 150; k++)
      stepEvt(EVT_W'({$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom}), 0, 0);
    chkBank("R6 random");

    // R7 saturation
    repeat (CMAX + 40) stepEvt(56'h4, 0, 0);
    regRd(16'h8080, v); chk("R7 saturated value", v, 64'(CMAX | (1 << CNT_W)));

    // R4 end holds values
    regWr(16'h8030, 1); mActive = 0;
    regRd(16'h8038, v); chk("R4 end status", v, 1);
    regRd(16'h8028, v); chk("R4 stopped", v, 0);
    repeat (6) stepEvt(56'h1 << 27, 0, 0);
    chkBank("R4 hold while stopped");

    // R3 restart clears, start while running does not
    regWr(16'h8028, 1); mActive = 1;
    for (int i = 0; i < 4; i++) mCnt[i] = 0;
    regRd(16'h8038, v); chk("R4 status cleared by start", v, 0);
    chkBank("R3 cleared by start");
    repeat (3) stepEvt(56'h4, 0, 0);
    regWr(16'h8028, 1);
    regRd(16'h8080, v); chk("R3 start while running", v, 3);

    // Free-running counters with bank stopped
    regWr(16'h8030, 1); mActive = 0;
    regWr(16'h80C0, 1);
    regRd(16'h80C0, v); chk("R8 enable readback", v, 1);
    repeat (10) stepEvt('0, 1, 1);
    regRd(16'h80D0, v); chk("R10 write count", v, 10);
    regRd(16'h80D8, v); chk("R8 read disabled", v, 0);
    regWr(16'h80C0, 3);
    repeat (7) stepEvt('0, 0, 1);
    regRd(16'h80D8, v); chk("R10 read count", v, 7);
    repeat (CMAX + 1) stepEvt('0, 1, 0);
    regRd(16'h80D0, v); chk("R10 wrap sets overflow", v, 64'(10 | (1 << CNT_W)));
    regRd(16'h80C8, v); chk("R9 control reads zero", v, 0);
    @(negedge clk);
    wrEn = 1; regAddr = 16'h80C8; wrData = 1; ddrWrPulse = 1; ddrRdPulse = 1;
    @(negedge clk);
    wrEn = 0; ddrWrPulse = 0; ddrRdPulse = 0;
    regRd(16'h80D0, v); chk("R9 clear wins over pulse", v, 0);
    regRd(16'h80D8, v); chk("R9 read untouched", v, 8);
    regWr(16'h80C8, 2);
    regRd(16'h80D8, v); chk("R9 read cleared", v, 0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog R12 got=hung exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule